// File: doc/BRIEF.md
# Interrupt Message Serial Framer

The framer turns one interrupt redirection entry into a timed sequence of two-bit symbols on a two-line, open-drain serial bus. A requester presents a 64-bit entry and a 4-bit arbitration ID and strobes start. The block then drives one symbol per clock. The frame begins with a start symbol. The ID follows, then a payload of header, vector and destination fields sent inverted, then a two-bit checksum, a postamble, and two status cycles in which the block only listens.

Each line is wired-AND. Driving 1 releases a line and driving 0 pulls it low. The block reads the resolved lines back while it sends its ID. If another agent pulls low a line this block released, the block has lost arbitration: it releases both lines and ends the frame at once, with no done pulse. A frame that completes ends with a one-cycle done pulse, and the four status bits read back in the listening cycles are held on an output for the requester.

Top module: `irq_msg_framer`

## Requirements
- R1: After reset both lines are released (2'b11), busy and done are 0 and the status output is 0. While busy is 0 the lines stay released.
- R2: Start sampled while idle makes busy 1 in the next cycle, which is frame cycle 1. In that cycle the lines show the start symbol 2'b10. Symbols are written {line1, line0}.
- R3: In cycles 2 to 5 line1 carries arbitration ID bits 3, 2, 1, 0 in that order, not inverted. Line0 is released.
- R4: Cycles 6, 7 and 8 carry, inverted, {entry[11], entry[10]}, then {entry[9], entry[8]}, then {entry[14], entry[15]}. Here entry[11] is the destination mode, entry[10:8] the delivery mode, entry[14] the level bit and entry[15] the trigger mode.
- R5: Cycles 9 to 12 carry the vector entry[7:0] inverted, two bits per cycle, bits 7:6 first and bits 1:0 last.
- R6: Cycles 13 to 16 carry the destination entry[63:56] inverted, two bits per cycle, bits 63:62 first.
- R7: Cycle 17 carries the inverse of the modulo-4 sum of the eleven uninverted payload symbols of cycles 6 to 16.
- R8: Cycle 18 carries the postamble symbol 2'b01.
- R9: In cycles 19 and 20 both lines are released. The status output becomes {line1, line0 read in cycle 19, line1, line0 read in cycle 20}. In the cycle after cycle 20, done is 1 for exactly one cycle and busy is 0.
- R10: In cycles 2 to 5, if line1 is released but reads 0, the next cycle has busy 0 and both lines released. No done pulse follows and the status output keeps its old value.
- R11: Start while busy is ignored. The frame in progress continues with the entry and ID it captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request, sampled when idle |
| entry_i | input | 64 | Redirection entry captured at start |
| arb_id_i | input | 4 | Arbitration ID captured at start |
| line_in_i | input | 2 | Resolved bus lines {line1, line0} |
| line_out_o | output | 2 | Line drivers, 1 releases, 0 pulls low |
| busy_o | output | 1 | A frame is in progress |
| done_o | output | 1 | One-cycle pulse after a completed frame |
| status_o | output | 4 | Status bits read back in cycles 19 and 20 |

## Verification
The checker watches several rules on every clock. Lines are released whenever the block is idle, and line0 is released throughout the ID cycles. An accepted start leads into cycle 1, and the frame counter steps by one with start pulses ignored. A lost bit ends the frame at once with no done, and the last status cycle is always followed by a single done pulse. The symbol contents need the bench's arithmetic model. That covers each field's inversion and bit order and the checksum, as well as the status read-back and the fact that a lost frame leaves the status unchanged. The bench sweeps every arbitration ID against many entries, forces a loss at each ID cycle where the ID bit is 1, and injects start strobes in the middle of frames.

// File: rtl/irq_fr_pkg.sv
package irq_fr_pkg;
   typedef logic [1:0] dibit_t;
   localparam dibit_t DIB_REL   = 2'b11;
   localparam dibit_t DIB_START = 2'b10;
   localparam dibit_t DIB_POST  = 2'b01;
   localparam int     HDR_CYC   = 3;
endpackage

// File: rtl/irq_fr_cksum.sv
module irq_fr_cksum #(
   parameter int N_DIB = 11,
   localparam int PAY_W = 2 * N_DIB
) (
   input  logic [PAY_W-1:0] payload_i,
   output logic [1:0]       sum_o
);
   logic [1:0] part [0:N_DIB];
   assign part[0] = 2'b00;
   for (genvar k = 0; k < N_DIB; k++) begin : g_acc
      assign part[k+1] = part[k] + payload_i[PAY_W-1-2*k -: 2];
   end
   assign sum_o = part[N_DIB];
endmodule

// File: rtl/irq_fr_sched.sv
module irq_fr_sched
   import irq_fr_pkg::*;
#(
   parameter int ARB_W  = 4,
   parameter int N_PAY  = 11,
   parameter int CYC_W  = 5,
   parameter int C_ARB0 = 2,
   localparam int PAY_W     = 2 * N_PAY,
   localparam int C_PAY0    = C_ARB0 + ARB_W,
   localparam int C_CK      = C_PAY0 + N_PAY,
   localparam int C_POST    = C_CK + 1
) (
   input  logic [CYC_W-1:0] cyc_i,
   input  logic             busy_i,
   input  logic [ARB_W-1:0] arb_id_i,
   input  logic [PAY_W-1:0] payload_i,
   input  logic [1:0]       sum_i,
   output dibit_t           drive_o
);
   dibit_t arb_dib [ARB_W];
   dibit_t pay_dib [N_PAY];

   for (genvar i = 0; i < ARB_W; i++) begin : g_arb
      assign arb_dib[i] = {arb_id_i[ARB_W-1-i], 1'b1};
   end
   for (genvar k = 0; k < N_PAY; k++) begin : g_pay
      assign pay_dib[k] = ~payload_i[PAY_W-1-2*k -: 2];
   end

   always_comb begin
      drive_o = DIB_REL;
      if (busy_i) begin
         if (cyc_i == CYC_W'(1)) drive_o = DIB_START;
         for (int i = 0; i < ARB_W; i++)
            if (cyc_i == CYC_W'(C_ARB0 + i)) drive_o = arb_dib[i];
         for (int k = 0; k < N_PAY; k++)
            if (cyc_i == CYC_W'(C_PAY0 + k)) drive_o = pay_dib[k];
         if (cyc_i == CYC_W'(C_CK))   drive_o = ~sum_i;
         if (cyc_i == CYC_W'(C_POST)) drive_o = DIB_POST;
      end
   end
endmodule

// File: rtl/irq_fr_seq.sv
module irq_fr_seq #(
   parameter int CYC_W     = 5,
   parameter int C_ARB0    = 2,
   parameter int C_ARB_END = 5,
   parameter int C_ST0     = 19,
   parameter int C_LAST    = 20,
   parameter int ST_W      = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [1:0]       line_in_i,
   input  logic             drive1_i,
   output logic             load_o,
   output logic [CYC_W-1:0] cyc_o,
   output logic             busy_o,
   output logic             done_o,
   output logic [ST_W-1:0]  status_o
);
   logic [CYC_W-1:0] cyc_q;
   logic             busy_q, done_q;
   logic [ST_W-1:0]  stat_q;
   logic [ST_W+1:0]  stat_nxt;
   logic             in_arb, lose;

   assign load_o   = start_i && !busy_q;
   assign in_arb   = busy_q && (cyc_q >= CYC_W'(C_ARB0)) && (cyc_q <= CYC_W'(C_ARB_END));
   assign lose     = in_arb && drive1_i && !line_in_i[1];
   assign stat_nxt = {stat_q, line_in_i};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cyc_q  <= '0;
         busy_q <= 1'b0;
         done_q <= 1'b0;
         stat_q <= '0;
      end else begin
         done_q <= 1'b0;
         if (load_o) begin
            busy_q <= 1'b1;
            cyc_q  <= CYC_W'(1);
         end else if (busy_q) begin
            if (lose) begin
               busy_q <= 1'b0;
               cyc_q  <= '0;
            end else if (cyc_q == CYC_W'(C_LAST)) begin
               busy_q <= 1'b0;
               cyc_q  <= '0;
               done_q <= 1'b1;
            end else begin
               cyc_q <= cyc_q + 1'b1;
            end
            if (cyc_q >= CYC_W'(C_ST0)) stat_q <= stat_nxt[ST_W-1:0];
         end
      end
   end

   assign cyc_o    = cyc_q;
   assign busy_o   = busy_q;
   assign done_o   = done_q;
   assign status_o = stat_q;
endmodule

// File: rtl/irq_msg_framer.sv
module irq_msg_framer
   import irq_fr_pkg::*;
#(
   parameter int ENTRY_W  = 64,
   parameter int ARB_W    = 4,
   parameter int VEC_W    = 8,
   parameter int VEC_LSB  = 0,
   parameter int DST_W    = 8,
   parameter int DST_LSB  = 56,
   parameter int DM_BIT   = 11,
   parameter int DLV_LSB  = 8,
   parameter int LVL_BIT  = 14,
   parameter int TRG_BIT  = 15,
   parameter int STAT_CYC = 2,
   localparam int ST_W      = 2 * STAT_CYC,
   localparam int C_ARB0    = 2,
   localparam int C_ARB_END = C_ARB0 + ARB_W - 1,
   localparam int N_PAY     = HDR_CYC + VEC_W / 2 + DST_W / 2,
   localparam int PAY_W     = 2 * N_PAY,
   localparam int C_CK      = C_ARB_END + 1 + N_PAY,
   localparam int C_ST0     = C_CK + 2,
   localparam int C_LAST    = C_ST0 + STAT_CYC - 1,
   localparam int CYC_W     = $clog2(C_LAST + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic [ENTRY_W-1:0] entry_i,
   input  logic [ARB_W-1:0]   arb_id_i,
   input  logic [1:0]         line_in_i,
   output logic [1:0]         line_out_o,
   output logic               busy_o,
   output logic               done_o,
   output logic [ST_W-1:0]    status_o
);
   if (VEC_W % 2 != 0 || DST_W % 2 != 0) begin : g_bad_width
      $error("vector and destination widths must be even");
   end
   if (DST_LSB + DST_W > ENTRY_W || VEC_LSB + VEC_W > ENTRY_W) begin : g_bad_field
      $error("field lies outside the entry");
   end
   if (STAT_CYC < 1 || ARB_W < 1) begin : g_bad_count
      $error("status and arbitration cycle counts must be positive");
   end

   logic [PAY_W-1:0] payload_q;
   logic [ARB_W-1:0] arb_q;
   logic [CYC_W-1:0] cyc_w;
   logic [1:0]       sum_w;
   logic             load_w, busy_w;
   dibit_t           drive_w;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         payload_q <= '0;
         arb_q     <= '0;
      end else if (load_w) begin
         payload_q <= {entry_i[DM_BIT], entry_i[DLV_LSB+2], entry_i[DLV_LSB+1], entry_i[DLV_LSB],
                       entry_i[LVL_BIT], entry_i[TRG_BIT],
                       entry_i[VEC_LSB +: VEC_W], entry_i[DST_LSB +: DST_W]};
         arb_q     <= arb_id_i;
      end
   end

   irq_fr_seq #(
      .CYC_W(CYC_W), .C_ARB0(C_ARB0), .C_ARB_END(C_ARB_END),
      .C_ST0(C_ST0), .C_LAST(C_LAST), .ST_W(ST_W)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .line_in_i(line_in_i),
      .drive1_i(drive_w[1]), .load_o(load_w), .cyc_o(cyc_w), .busy_o(busy_w),
      .done_o(done_o), .status_o(status_o)
   );

   irq_fr_cksum #(.N_DIB(N_PAY)) u_ck (.payload_i(payload_q), .sum_o(sum_w));

   irq_fr_sched #(
      .ARB_W(ARB_W), .N_PAY(N_PAY), .CYC_W(CYC_W), .C_ARB0(C_ARB0)
   ) u_sched (
      .cyc_i(cyc_w), .busy_i(busy_w), .arb_id_i(arb_q), .payload_i(payload_q),
      .sum_i(sum_w), .drive_o(drive_w)
   );

   assign line_out_o = drive_w;
   assign busy_o     = busy_w;
endmodule

// File: rtl/irq_fr_chk.sv
module irq_fr_chk #(
   parameter int CYC_W     = 5,
   parameter int C_ARB0    = 2,
   parameter int C_ARB_END = 5,
   parameter int C_LAST    = 20
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic [1:0]       line_in_i,
   input logic [1:0]       line_out_o,
   input logic             busy_o,
   input logic             done_o,
   input logic [CYC_W-1:0] cyc
);
   logic win, lost;
   assign win  = busy_o && (cyc >= CYC_W'(C_ARB0)) && (cyc <= CYC_W'(C_ARB_END));
   assign lost = win && line_out_o[1] && !line_in_i[1];

   p_idle_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> line_out_o == 2'b11);
   p_start_begins_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> (busy_o && cyc == CYC_W'(1)));
   p_arb_line0_r3: assert property (@(posedge clk) disable iff (!rst_n)
      win |-> line_out_o[0]);
   p_done_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && cyc == CYC_W'(C_LAST)) |=> (done_o && !busy_o));
   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   p_lose_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
      lost |=> (!busy_o && !done_o));
   p_advance_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && cyc != CYC_W'(C_LAST) && !lost) |=> (busy_o && cyc == CYC_W'($past(cyc) + 1'b1)));
endmodule

bind irq_msg_framer irq_fr_chk #(
   .CYC_W(CYC_W), .C_ARB0(C_ARB0), .C_ARB_END(C_ARB_END), .C_LAST(C_LAST)
) u_chk (
   .clk(clk), .rst_n(rst_n), .start_i(start_i), .line_in_i(line_in_i),
   .line_out_o(line_out_o), .busy_o(busy_o), .done_o(done_o), .cyc(cyc_w)
);

// File: tb/irq_msg_framer_tb.sv
module irq_msg_framer_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [63:0] entry_i = '0;
   logic [3:0]  arb_id_i = '0;
   logic [1:0]  other_q = 2'b11;
   logic [1:0]  line_in_i, line_out_o;
   logic        busy_o, done_o;
   logic [3:0]  status_o;
   int n_chk = 0, n_err = 0;

   always #5 clk = ~clk;
   assign line_in_i = line_out_o & other_q;

   irq_msg_framer u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .entry_i(entry_i), .arb_id_i(arb_id_i),
      .line_in_i(line_in_i), .line_out_o(line_out_o), .busy_o(busy_o), .done_o(done_o),
      .status_o(status_o)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [1:0] cks(logic [63:0] e);
      logic [1:0] s;
      s = {e[11], e[10]} + e[9:8] + {e[14], e[15]};
      for (int j = 0; j < 4; j++) s = s + e[2*j +: 2] + e[56 + 2*j +: 2];
      return s;
   endfunction

   function automatic logic [1:0] exp_drive(logic [63:0] e, logic [3:0] id, int c);
      if (c == 1) return 2'b10;
      if (c >= 2 && c <= 5) return {id[5-c], 1'b1};
      if (c == 6) return ~{e[11], e[10]};
      if (c == 7) return ~e[9:8];
      if (c == 8) return ~{e[14], e[15]};
      if (c >= 9 && c <= 12) return ~e[2*(12-c) +: 2];
      if (c >= 13 && c <= 16) return ~e[56 + 2*(16-c) +: 2];
      if (c == 17) return ~cks(e);
      if (c == 18) return 2'b01;
      return 2'b11;
   endfunction

   function automatic string tag_of(int c);
      if (c == 1) return "R2";
      if (c <= 5) return "R3";
      if (c <= 8) return "R4";
      if (c <= 12) return "R5";
      if (c <= 16) return "R6";
      if (c == 17) return "R7";
      if (c == 18) return "R8";
      return "R9";
   endfunction

   // lose_at: 0 means no contention; inj: strobe start mid-frame (R11)
   task automatic frame(logic [63:0] e, logic [3:0] id, int lose_at, logic [3:0] pat, bit inj);
      logic [3:0] st_before;
      st_before = status_o;
      @(negedge clk);
      entry_i = e; arb_id_i = id; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      for (int c = 1; c <= 20; c++) begin
         chk(inj ? "R11 lines" : tag_of(c), 32'(line_out_o), 32'(exp_drive(e, id, c)));
         chk("R2 busy", 32'(busy_o), 1);
         start_i = 1'b0;
         if (inj && c == 8) begin
            start_i = 1'b1; entry_i = ~e; arb_id_i = ~id;
         end
         if (c == lose_at) other_q = 2'b01;
         else if (c == 19) other_q = pat[3:2];
         else if (c == 20) other_q = pat[1:0];
         else other_q = 2'b11;
         @(negedge clk);
         if (c == lose_at) begin
            other_q = 2'b11;
            chk("R10 busy", 32'(busy_o), 0);
            chk("R10 lines", 32'(line_out_o), 32'h3);
            for (int w = 0; w < 3; w++) begin
               chk("R10 done", 32'(done_o), 0);
               @(negedge clk);
            end
            chk("R10 status", 32'(status_o), 32'(st_before));
            return;
         end
      end
      start_i = 1'b0;
      other_q = 2'b11;
      chk("R9 done", 32'(done_o), 1);
      chk("R9 busy", 32'(busy_o), 0);
      chk("R9 status", 32'(status_o), 32'(pat));
      chk("R1 idle lines", 32'(line_out_o), 32'h3);
      @(negedge clk);
      chk("R9 done pulse", 32'(done_o), 0);
   endtask

   task automatic summary;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 lines", 32'(line_out_o), 32'h3);
      chk("R1 busy", 32'(busy_o), 0);
      chk("R1 done", 32'(done_o), 0);
      chk("R1 status", 32'(status_o), 0);
      rst_n = 1'b1;
      for (int k = 0; k < 24; k++) begin
         for (int id = 0; id < 16; id++) begin
            frame(64'h9E37_79B9_7F4A_7C15 * 64'(k * 16 + id + 1), 4'(id), 0, 4'(k + id), (k % 5) == 3);
         end
      end
      frame(64'h0, 4'h0, 0, 4'h0, 1'b0);
      frame(64'hFFFF_FFFF_FFFF_FFFF, 4'hF, 0, 4'hF, 1'b0);
      for (int id = 0; id < 16; id++) begin
         for (int c = 2; c <= 5; c++) begin
            if (id[5-c]) frame(64'hA5C3_0000_0000_4E7B * 64'(id + c), 4'(id), c, 4'h6, 1'b0);
         end
      end
      frame(64'h1234_5678_9ABC_DEF0, 4'h9, 0, 4'hA, 1'b0);
      summary();
      $finish;
   end
endmodule